// File: doc/BRIEF.md
# Root-Port Power-Management Event Capture with Requester Retry

This block handles power-management event (PME) messages at both ends of a link. On the root side it takes PME messages, each tagged with a 16-bit requester ID. It queues them in a small waiting buffer and presents the oldest one through a status flag and an ID field. When interrupt generation is enabled, the status flag drives an interrupt line. Software acknowledges an event by writing 1 to the status flag. That write also brings the next queued ID forward.

A message that finds the buffer full is thrown away, so the receive path never stalls. Delivery then rests on the requester side. There a request is transmitted only while the link is in its active state, and it is sent again whenever a parameterized timeout passes without a serviced indication. The default timeout is 25,000,000 cycles, which is 100 ms at 250 MHz.

Top module: `pme_event_hub`

## Requirements
- R1: When the status flag is clear and the buffer is empty, an accepted message sets `pmeStatus` and shows its ID on `pmeReqId` two clock edges after the edge that samples `msgValid`.
- R2: `pmeIrq` is high exactly when `pmeStatus` is high and `intEnable` is high.
- R3: While `pmeStatus` is high, it and `pmeReqId` keep their values until a cycle with `statusClr` high. A `statusClr` while `pmeStatus` is low has no effect.
- R4: A `statusClr` while `pmeStatus` is high shows the next-oldest buffered ID after one edge, with `pmeStatus` staying high. If the buffer is empty, `pmeStatus` falls instead and `pmeReqId` keeps its last value.
- R5: Besides the ID on display, up to DEPTH (default 2) IDs wait in arrival order. A message that arrives while DEPTH IDs are waiting is discarded and never appears.
- R6: A `reqStart` pulse with `linkActive` high makes `txPme` high for one cycle, in the cycle after the pulse.
- R7: `txPme` is never high while `linkActive` is low. A send that falls due while the link is down goes out in the first cycle `linkActive` is high again.
- R8: While a request is outstanding and the link stays active, `txPme` repeats exactly TIMEOUT_CYC cycles after the previous send.
- R9: After `reqServiced`, `txPme` stays low until the next `reqStart`.
- R10: After reset, `pmeStatus`, `pmeReqId`, `pmeIrq` and `txPme` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Incoming PME message strobe |
| msgReqId | input | ID_W (16) | Requester ID of the incoming message |
| statusClr | input | 1 | Write-1 to the status flag |
| intEnable | input | 1 | PME interrupt enable |
| pmeStatus | output | 1 | PME status flag |
| pmeReqId | output | ID_W (16) | Requester ID of the event on display |
| pmeIrq | output | 1 | Interrupt request |
| reqStart | input | 1 | Requester: begin a PME request |
| linkActive | input | 1 | Requester: link is in its active state |
| reqServiced | input | 1 | Requester: request has been serviced |
| txPme | output | 1 | Requester: send a PME message this cycle |

## Verification
A wrong buffer count or pointer appears at the ports within a few acknowledge writes. It shows up either as an ID out of arrival order, as a discarded ID reappearing, or as `pmeStatus` staying high when it should have fallen. A faulty resend counter shifts `txPme` by one or more cycles away from the TIMEOUT_CYC spacing, so it is caught on the first retry. A lost pending flag shows up as a send during link-down, or as a send after service.

// File: rtl/pme_hub_pkg.sv
`timescale 1ns/1ps
package pme_hub_pkg;
  // Strobes from control to the root-side datapath
  typedef struct packed {
    logic push;       // write incoming ID into the waiting buffer
    logic popLoad;    // move buffer head into the status/ID register
    logic clearStat;  // drop the status flag
  } rootStrobe_t;
endpackage

// File: rtl/pme_hub_dp.sv
`timescale 1ns/1ps
module pme_hub_dp
  import pme_hub_pkg::*;
#(
  parameter int ID_W  = 16,
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rootStrobe_t      stb,
  input  logic [ID_W-1:0]  msgReqId,
  output logic [CNT_W-1:0] fifoCount,
  output logic             pmeStatus,
  output logic [ID_W-1:0]  pmeReqId
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  slotId [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (stb.push && wrPtr == PTR_W'(g)) slotId[g] <= msgReqId;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (stb.push)    wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (stb.popLoad) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      fifoCount <= fifoCount + CNT_W'(stb.push) - CNT_W'(stb.popLoad);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmeStatus <= 1'b0;
      pmeReqId  <= '0;
    end else if (stb.popLoad) begin
      pmeStatus <= 1'b1;
      pmeReqId  <= slotId[rdPtr];
    end else if (stb.clearStat) begin
      pmeStatus <= 1'b0;
    end
  end
endmodule

// File: rtl/pme_hub_ctrl.sv
`timescale 1ns/1ps
module pme_hub_ctrl
  import pme_hub_pkg::*;
#(
  parameter int DEPTH       = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1),
  parameter int TIMEOUT_CYC = 25_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic             statusClr,
  input  logic             intEnable,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             pmeStatus,
  output rootStrobe_t      stb,
  output logic             pmeIrq,
  input  logic             reqStart,
  input  logic             linkActive,
  input  logic             reqServiced,
  output logic             txPme
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] TMAX = TMR_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  // Root side: admission, promotion and acknowledge
  always_comb begin
    stb.push      = msgValid && (fifoCount != FULL);
    stb.popLoad   = (fifoCount != '0) && (!pmeStatus || statusClr);
    stb.clearStat = statusClr && pmeStatus && (fifoCount == '0);
  end

  assign pmeIrq = pmeStatus && intEnable;

  // Requester side: saturating resend timer
  logic             pending;
  logic [TMR_W-1:0] tmr;
  logic             expired;

  assign expired = (tmr == TMAX);
  assign txPme   = pending && expired && linkActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      tmr     <= '0;
    end else if (reqServiced) begin
      pending <= 1'b0;
    end else if (reqStart) begin
      pending <= 1'b1;
      tmr     <= TMAX;
    end else if (pending) begin
      if (txPme)         tmr <= TMR_W'(1);
      else if (!expired) tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/pme_event_hub.sv
`timescale 1ns/1ps
module pme_event_hub
  import pme_hub_pkg::*;
#(
  parameter int ID_W        = 16,
  parameter int DEPTH       = 2,
  parameter int TIMEOUT_CYC = 25_000_000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            msgValid,
  input  logic [ID_W-1:0] msgReqId,
  input  logic            statusClr,
  input  logic            intEnable,
  output logic            pmeStatus,
  output logic [ID_W-1:0] pmeReqId,
  output logic            pmeIrq,
  input  logic            reqStart,
  input  logic            linkActive,
  input  logic            reqServiced,
  output logic            txPme
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rootStrobe_t      stb;
  logic [CNT_W-1:0] fifoCount;

  pme_hub_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .statusClr(statusClr),
    .intEnable(intEnable), .fifoCount(fifoCount), .pmeStatus(pmeStatus),
    .stb(stb), .pmeIrq(pmeIrq), .reqStart(reqStart), .linkActive(linkActive),
    .reqServiced(reqServiced), .txPme(txPme)
  );

  pme_hub_dp #(.ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .msgReqId(msgReqId),
    .fifoCount(fifoCount), .pmeStatus(pmeStatus), .pmeReqId(pmeReqId)
  );
endmodule

// File: rtl/pme_event_hub_chk.sv
`timescale 1ns/1ps
module pme_event_hub_chk #(
  parameter int ID_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            msgValid,
  input logic            statusClr,
  input logic            intEnable,
  input logic            pmeStatus,
  input logic [ID_W-1:0] pmeReqId,
  input logic            pmeIrq,
  input logic            reqStart,
  input logic            linkActive,
  input logic            reqServiced,
  input logic            txPme
);
  AST_MSG_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (!pmeStatus && msgValid) |=> ##1 pmeStatus); // R1
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    pmeIrq |-> pmeStatus); // R2
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pmeStatus && !statusClr) |=> (pmeStatus && $stable(pmeReqId))); // R3
  AST_TX_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    txPme |-> linkActive); // R7
  AST_NO_TX_AFTER_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (reqServiced && !reqStart) |=> !txPme); // R9
endmodule

bind pme_event_hub pme_event_hub_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .statusClr(statusClr),
  .intEnable(intEnable), .pmeStatus(pmeStatus), .pmeReqId(pmeReqId),
  .pmeIrq(pmeIrq), .reqStart(reqStart), .linkActive(linkActive),
  .reqServiced(reqServiced), .txPme(txPme)
);

// File: tb/sim_pme_event_hub.sv
`timescale 1ns/1ps
module sim_pme_event_hub;
  localparam int TMO = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic [15:0] msgReqId = '0;
  logic        statusClr = 1'b0;
  logic        intEnable = 1'b0;
  logic        pmeStatus;
  logic [15:0] pmeReqId;
  logic        pmeIrq;
  logic        reqStart = 1'b0;
  logic        linkActive = 1'b0;
  logic        reqServiced = 1'b0;
  logic        txPme;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk; // 250 MHz

  pme_event_hub #(.ID_W(16), .DEPTH(2), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReqId(msgReqId),
    .statusClr(statusClr), .intEnable(intEnable), .pmeStatus(pmeStatus),
    .pmeReqId(pmeReqId), .pmeIrq(pmeIrq), .reqStart(reqStart),
    .linkActive(linkActive), .reqServiced(reqServiced), .txPme(txPme)
  );

  typedef struct packed {
    logic        msg;
    logic [15:0] id;
    logic        clr;
    logic        en;
    logic        expSt;
    logic [15:0] expId;
    logic        expIrq;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1A01, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 8'd1}, // R1 accepted, not shown yet
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h1A01, 1'b1, 8'd1}, // R1 shown, R2 irq on
    '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1A01, 1'b0, 8'd2}, // R2 irq masked
    '{1'b1, 16'h2B02, 1'b0, 1'b0, 1'b1, 16'h1A01, 1'b0, 8'd3}, // R3 held while B queued
    '{1'b1, 16'h3C03, 1'b0, 1'b0, 1'b1, 16'h1A01, 1'b0, 8'd3}, // R3 held while C queued
    '{1'b1, 16'h4D04, 1'b0, 1'b1, 1'b1, 16'h1A01, 1'b1, 8'd5}, // R5 D dropped (buffer full)
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h2B02, 1'b1, 8'd4}, // R4 next is B
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h3C03, 1'b1, 8'd5}, // R5 order kept, C
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h3C03, 1'b0, 8'd5}, // R5 D never shown, R4 fall
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h3C03, 1'b0, 8'd3}, // R3 clear when low: no effect
    '{1'b1, 16'h5E05, 1'b1, 1'b1, 1'b0, 16'h3C03, 1'b0, 8'd1}, // R1 E accepted
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h5E05, 1'b1, 8'd1}, // R1 E shown
    '{1'b1, 16'h6F06, 1'b1, 1'b1, 1'b0, 16'h5E05, 1'b0, 8'd4}, // R4 clear with empty buffer
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h6F06, 1'b1, 8'd1}  // R1 F shown
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    int seen;
    intEnable  = 1'b1;
    linkActive = 1'b1;
    repeat (3) tick();
    // R10 reset values
    check("R10 status", {31'd0, pmeStatus}, 32'd0);
    check("R10 id", {16'd0, pmeReqId}, 32'd0);
    check("R10 irq", {31'd0, pmeIrq}, 32'd0);
    check("R10 tx", {31'd0, txPme}, 32'd0);
    rstN = 1'b1;
    tick();

    // Root side vector walk
    for (int i = 0; i < NV; i++) begin
      msgValid  = VECS[i].msg;
      msgReqId  = VECS[i].id;
      statusClr = VECS[i].clr;
      intEnable = VECS[i].en;
      tick();
      check($sformatf("R%0d status v%0d", VECS[i].tag, i), {31'd0, pmeStatus}, {31'd0, VECS[i].expSt});
      check($sformatf("R%0d id v%0d", VECS[i].tag, i), {16'd0, pmeReqId}, {16'd0, VECS[i].expId});
      check($sformatf("R2 irq v%0d", i), {31'd0, pmeIrq}, {31'd0, VECS[i].expIrq});
    end
    msgValid = 1'b0; statusClr = 1'b0;
    tick();

    // R6 first send one cycle after the start pulse
    reqStart = 1'b1;
    tick();
    reqStart = 1'b0;
    check("R6 tx after start", {31'd0, txPme}, 32'd1);

    // R8 resend spacing equals TMO
    gap = 0;
    for (int k = 1; k <= TMO + 2; k++) begin
      tick();
      if (txPme && gap == 0) gap = k;
    end
    check("R8 resend spacing", gap, TMO);

    // R7 link down: nothing sent, then immediate send on return
    linkActive = 1'b0;
    seen = 0;
    for (int k = 0; k < TMO + 10; k++) begin
      tick();
      if (txPme) seen++;
    end
    check("R7 no tx while link down", seen, 0);
    linkActive = 1'b1;
    #1;
    check("R7 tx on link return", {31'd0, txPme}, 32'd1);
    tick();
    check("R6 single-cycle tx", {31'd0, txPme}, 32'd0);

    // R9 serviced stops resends
    reqServiced = 1'b1;
    tick();
    reqServiced = 1'b0;
    seen = 0;
    for (int k = 0; k < 3 * TMO; k++) begin
      if (txPme) seen++;
      tick();
    end
    check("R9 no tx after service", seen, 0);

    // R7 start while link down, send once link active
    linkActive = 1'b0;
    reqStart = 1'b1;
    tick();
    reqStart = 1'b0;
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      if (txPme) seen++;
      tick();
    end
    check("R7 held start while down", seen, 0);
    linkActive = 1'b1;
    #1;
    check("R7 send on first active cycle", {31'd0, txPme}, 32'd1);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule